// File: doc/BRIEF.md
# Leveled Interrupt Acknowledge Controller

This block collects interrupt requests from a bank of sticky event flags, gives each request a programmable level and priority, and answers acknowledge reads with a vector byte. Nineteen event lines feed flags at source numbers 8 to 26: sixteen buffer events, then an error event (24), a bus-off event (25) and a wake-up event (26). All other source numbers from 0 to 63 hold no state and read as zero. Software clears a flag by writing 1 to its bit, but only after it has seen that bit read back as 1.

An acknowledge selects one of eight behaviours through a 3-bit select. Selects 1 to 7 ask for the best request at that one level. Select 0 is the software acknowledge: a service routine uses it to find the best request pending at any level without taking another exception. The same port serves explicit reads and hardware acknowledge cycles. Each acknowledge returns a vector byte and records the winner's level and priority in a status register. A 3-bit output tells the CPU the highest level that has an active request.

Top module: `lvl_irq_ack_ctrl`

## Requirements
- R1: After reset all flags read 0, the mask register reads 64'h0000_0000_07FF_FF00 (every live source masked), every configuration register and the status register read 0, `irq_lvl` is 0 and `ack_vld` is 0.
- R2: Bit k of `src_evt` feeds source 8+k. For source numbers outside 8..26, the flag, mask and configuration bits cannot be written and always read 0.
- R3: An event sets its flag at the next clock edge. The flag then stays set until a valid clear. Writing 0 to a flag bit at address 0 has no effect.
- R4: Writing 1 to a flag bit at address 0 clears it only if a read of address 0 has returned that bit as 1 since it was last cleared. If an event arrives in the same cycle as the clear, the flag stays set.
- R5: A source requests when its flag is 1, its mask bit (address 1, bit = source number, 1 = masked) is 0, and its level is not 0. The configuration register of source n is at address 64+n, with level in bits [5:3] and priority in bits [2:0].
- R6: `ack_req` with `ack_lvl` = n (1..7) considers only requests at level n. Among them it picks the highest priority, and on equal priority the lower source number. `ack_vld` pulses at the next edge with `ack_vec` = 128 + source number.
- R7: `ack_req` with `ack_lvl` = 0 picks across all levels: higher level first, then higher priority, then lower source number. It returns the vector in the same way.
- R8: When no request qualifies, `ack_vec` is 8'h18 and the status register is written with 0.
- R9: The status register at address 2 holds {level[5:3], priority[2:0]} of the last acknowledge winner. It is written at the same edge that raises `ack_vld` and holds its value while no acknowledge occurs.
- R10: `irq_lvl` equals the highest level among active requests, or 0 if there are none, one clock after the flag, mask or configuration change.
- R11: `rd_data` shows the addressed register one clock after `rd_en`. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_evt | input | 19 | Event pulses for sources 8..26 |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 7 | Read address |
| rd_data | output | 64 | Registered read data |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 7 | Write address |
| wr_data | input | 64 | Write data |
| ack_req | input | 1 | Acknowledge request |
| ack_lvl | input | 3 | Acknowledge select: 0 software, 1..7 level |
| ack_vld | output | 1 | Acknowledge response valid (one-cycle pulse) |
| ack_vec | output | 8 | Vector byte of the acknowledge |
| irq_lvl | output | 3 | Highest active request level |

## Verification
A flag that drops without an armed clear, or a missing arm bit, shows up at the next read of address 0. It also shows up one clock later as a changed `irq_lvl`. A wrong comparison in the selection shows up at the very next `ack_vld` as a wrong vector, and in the status word read two cycles later. Tie cases and spurious cases are set up on purpose, because random stimulus alone rarely hits equal keys.

// File: rtl/lia_pkg.sv
package lia_pkg;

    localparam int NUM_SRC  = 64;
    localparam int SRC_W    = $clog2(NUM_SRC);
    localparam int LIVE_LO  = 8;
    localparam int LIVE_HI  = 26;
    localparam int NUM_LIVE = LIVE_HI - LIVE_LO + 1;
    localparam int LVL_W    = 3;
    localparam int PRI_W    = 3;
    localparam int ADDR_W   = SRC_W + 1;
    localparam int VEC_W    = 8;
    localparam int VEC_BASE = 128;
    localparam logic [VEC_W-1:0] SPUR_VEC = 8'h18;

    typedef struct packed {
        logic [LVL_W-1:0] lvl;
        logic [PRI_W-1:0] pri;
    } lp_t;

    typedef struct packed {
        logic             hit;
        logic [SRC_W-1:0] src;
        lp_t              lp;
    } win_t;

    typedef enum logic [ADDR_W-1:0] {
        ADR_FLAG = 'd0,
        ADR_MASK = 'd1,
        ADR_STAT = 'd2
    } reg_adr_e;

    function automatic logic src_is_live(input int s);
        return (s >= LIVE_LO) && (s <= LIVE_HI);
    endfunction

    function automatic logic [VEC_W-1:0] vec_of(input win_t w);
        return w.hit ? VEC_W'(VEC_BASE + int'(w.src)) : SPUR_VEC;
    endfunction

endpackage

// File: rtl/icu_flag_bank.sv
module icu_flag_bank
    import lia_pkg::*;
#(
    parameter int NSRC = NUM_SRC,
    parameter int LO   = LIVE_LO,
    parameter int HI   = LIVE_HI,
    localparam int NL  = HI - LO + 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NL-1:0]   evt,
    input  logic            rd_flags,
    input  logic            clr_en,
    input  logic [NL-1:0]   clr_data,
    output logic [NSRC-1:0] flags_o
);

    logic [NSRC-1:0] armed;
    logic [NSRC-1:0] clr_req;

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        if (s >= LO && s <= HI) begin : g_live
            logic f_q, a_q, clr_ok;
            assign clr_req[s] = clr_en & clr_data[s-LO];
            assign clr_ok     = clr_req[s] & a_q & f_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    f_q <= 1'b0;
                    a_q <= 1'b0;
                end else begin
                    f_q <= (f_q & ~clr_ok) | evt[s-LO];
                    a_q <= (a_q | (rd_flags & f_q)) & ~clr_ok;
                end
            end
            assign flags_o[s] = f_q;
            assign armed[s]   = a_q;
        end else begin : g_dead
            assign clr_req[s] = 1'b0;
            assign flags_o[s] = 1'b0;
            assign armed[s]   = 1'b0;
        end
    end

    // R3: a set flag falls only when a clear was requested for it
    a_r3_sticky: assert property (@(posedge clk) disable iff (rst)
        ($past(flags_o) & ~flags_o & ~$past(clr_req)) == '0);

    // R4: a flag never falls unless it was armed by a read
    a_r4_needs_arm: assert property (@(posedge clk) disable iff (rst)
        ($past(flags_o & ~armed) & ~flags_o) == '0);

endmodule

// File: rtl/icu_cfg_regs.sv
module icu_cfg_regs
    import lia_pkg::*;
#(
    parameter int NSRC = NUM_SRC,
    parameter int LO   = LIVE_LO,
    parameter int HI   = LIVE_HI,
    localparam int AW  = $clog2(NSRC) + 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [AW-1:0]       wr_addr,
    input  logic [NSRC-1:0]     wr_data,
    output logic [NSRC-1:0]     mask_o,
    output lp_t  [NSRC-1:0]     cfg_o
);

    logic mask_wr, cfg_wr;
    logic unused_wr_bits;

    assign mask_wr        = wr_en && (wr_addr == AW'(ADR_MASK));
    assign cfg_wr         = wr_en && wr_addr[AW-1];
    assign unused_wr_bits = ^wr_data;

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        if (s >= LO && s <= HI) begin : g_live
            logic m_q;
            lp_t  c_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    m_q <= 1'b1;
                    c_q <= '0;
                end else begin
                    if (mask_wr) m_q <= wr_data[s];
                    if (cfg_wr && (wr_addr[AW-2:0] == (AW-1)'(s)))
                        c_q <= lp_t'(wr_data[LVL_W+PRI_W-1:0]);
                end
            end
            assign mask_o[s] = m_q;
            assign cfg_o[s]  = c_q;
        end else begin : g_dead
            assign mask_o[s] = 1'b0;
            assign cfg_o[s]  = '0;
        end
    end

endmodule

// File: rtl/icu_arbiter.sv
module icu_arbiter
    import lia_pkg::*;
#(
    parameter int NSRC = NUM_SRC
) (
    input  logic [NSRC-1:0] req,
    input  lp_t  [NSRC-1:0] cfg,
    input  logic            filt_en,
    input  logic [LVL_W-1:0] filt_lvl,
    output win_t            win
);

    // ascending scan with strict compare: equal keys keep the lower source
    always_comb begin
        win = '0;
        for (int s = 0; s < NSRC; s++) begin
            if (req[s] && (!filt_en || cfg[s].lvl == filt_lvl) &&
                (!win.hit || cfg[s] > win.lp)) begin
                win.hit = 1'b1;
                win.src = SRC_W'(s);
                win.lp  = cfg[s];
            end
        end
    end

endmodule

// File: rtl/lvl_irq_ack_ctrl.sv
module lvl_irq_ack_ctrl
    import lia_pkg::*;
#(
    parameter int NSRC = NUM_SRC,
    parameter int LO   = LIVE_LO,
    parameter int HI   = LIVE_HI,
    localparam int NL  = HI - LO + 1,
    localparam int AW  = $clog2(NSRC) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NL-1:0]     src_evt,
    input  logic              rd_en,
    input  logic [AW-1:0]     rd_addr,
    output logic [NSRC-1:0]   rd_data,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [NSRC-1:0]   wr_data,
    input  logic              ack_req,
    input  logic [LVL_W-1:0]  ack_lvl,
    output logic              ack_vld,
    output logic [VEC_W-1:0]  ack_vec,
    output logic [LVL_W-1:0]  irq_lvl
);

    logic [NSRC-1:0] flags, mask, req;
    lp_t  [NSRC-1:0] cfg;
    win_t            win;
    lp_t             stat_q;
    logic [LVL_W-1:0] top_lvl;
    logic [NSRC-1:0] rd_mux;

    icu_flag_bank #(.NSRC(NSRC), .LO(LO), .HI(HI)) u_flags (
        .clk      (clk),
        .rst      (rst),
        .evt      (src_evt),
        .rd_flags (rd_en && (rd_addr == AW'(ADR_FLAG))),
        .clr_en   (wr_en && (wr_addr == AW'(ADR_FLAG))),
        .clr_data (wr_data[HI:LO]),
        .flags_o  (flags)
    );

    icu_cfg_regs #(.NSRC(NSRC), .LO(LO), .HI(HI)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .mask_o  (mask),
        .cfg_o   (cfg)
    );

    for (genvar s = 0; s < NSRC; s++) begin : g_req
        assign req[s] = flags[s] & ~mask[s] & (cfg[s].lvl != '0);
    end

    icu_arbiter #(.NSRC(NSRC)) u_arb (
        .req      (req),
        .cfg      (cfg),
        .filt_en  (ack_lvl != '0),
        .filt_lvl (ack_lvl),
        .win      (win)
    );

    always_comb begin
        top_lvl = '0;
        for (int s = 0; s < NSRC; s++)
            if (req[s] && cfg[s].lvl > top_lvl) top_lvl = cfg[s].lvl;
    end

    always_comb begin
        rd_mux = '0;
        if (rd_addr[AW-1])                   rd_mux = NSRC'(cfg[rd_addr[AW-2:0]]);
        else if (rd_addr == AW'(ADR_FLAG))   rd_mux = flags;
        else if (rd_addr == AW'(ADR_MASK))   rd_mux = mask;
        else if (rd_addr == AW'(ADR_STAT))   rd_mux = NSRC'(stat_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
            stat_q  <= '0;
            ack_vld <= 1'b0;
            ack_vec <= '0;
            irq_lvl <= '0;
        end else begin
            if (rd_en) rd_data <= rd_mux;
            ack_vld <= ack_req;
            if (ack_req) begin
                ack_vec <= vec_of(win);
                stat_q  <= win.hit ? win.lp : '0;
            end
            irq_lvl <= top_lvl;
        end
    end

    // R6: a level acknowledge that found a winner reports the asked level
    a_r6_level_match: assert property (@(posedge clk) disable iff (rst)
        (ack_req && ack_lvl != '0) |=> (ack_vec == SPUR_VEC || stat_q.lvl == $past(ack_lvl)));

    // R6: returned vectors stay in the live source range or are spurious
    a_r6_vec_range: assert property (@(posedge clk) disable iff (rst)
        ack_vld |-> (ack_vec == SPUR_VEC ||
                     (ack_vec >= VEC_W'(VEC_BASE + LO) && ack_vec <= VEC_W'(VEC_BASE + HI))));

    // R8: a spurious answer leaves the status word at zero
    a_r8_spur_stat: assert property (@(posedge clk) disable iff (rst)
        (ack_vld && ack_vec == SPUR_VEC) |-> stat_q == '0);

    // R9: status holds when no acknowledge is taken
    a_r9_stat_hold: assert property (@(posedge clk) disable iff (rst)
        !ack_req |=> $stable(stat_q));

    // R10: no requests one cycle ago means no level now
    a_r10_idle_lvl: assert property (@(posedge clk) disable iff (rst)
        !$past(|req) |-> irq_lvl == '0);

endmodule

// File: tb/lvl_irq_ack_ctrl_tb.sv
module lvl_irq_ack_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam logic [63:0] LIVE = 64'h0000_0000_07FF_FF00;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [18:0] src_evt = '0;
    logic        rd_en = 1'b0;
    logic [6:0]  rd_addr = '0;
    logic [63:0] rd_data;
    logic        wr_en = 1'b0;
    logic [6:0]  wr_addr = '0;
    logic [63:0] wr_data = '0;
    logic        ack_req = 1'b0;
    logic [2:0]  ack_lvl = '0;
    logic        ack_vld;
    logic [7:0]  ack_vec;
    logic [2:0]  irq_lvl;

    int n_chk = 0;
    int n_bad = 0;

    logic [63:0] mflag = '0, marm = '0, mmask = LIVE;
    logic [2:0]  mlvl [64];
    logic [2:0]  mpri [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    lvl_irq_ack_ctrl u_dut (
        .clk(clk), .rst(rst), .src_evt(src_evt),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ack_req(ack_req), .ack_lvl(ack_lvl),
        .ack_vld(ack_vld), .ack_vec(ack_vec), .irq_lvl(irq_lvl)
    );

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int model_pick(input logic [2:0] f);
        int best = 0;
        logic [5:0] bk = '0;
        for (int s = 1; s < 64; s++)
            if (mflag[s] && !mmask[s] && mlvl[s] != 0 && (f == 0 || mlvl[s] == f) &&
                (best == 0 || {mlvl[s], mpri[s]} > bk)) begin
                best = s;
                bk = {mlvl[s], mpri[s]};
            end
        return best;
    endfunction

    function automatic logic [2:0] model_irq();
        logic [2:0] m = '0;
        for (int s = 1; s < 64; s++)
            if (mflag[s] && !mmask[s] && mlvl[s] > m) m = mlvl[s];
        return m;
    endfunction

    function automatic logic [63:0] model_reg(input logic [6:0] a);
        if (a[6]) return (LIVE[a[5:0]]) ? 64'({mlvl[a[5:0]], mpri[a[5:0]]}) : 64'd0;
        if (a == 0) return mflag;
        if (a == 1) return mmask;
        return 64'd0;
    endfunction

    task automatic reg_read(input logic [6:0] a, output logic [63:0] d);
        rd_en = 1'b1; rd_addr = a;
        cyc();
        rd_en = 1'b0;
        d = rd_data;
        if (a == 0) marm = marm | mflag;
    endtask

    task automatic read_chk(input logic [6:0] a, input string tag);
        logic [63:0] d, e;
        e = model_reg(a);
        reg_read(a, d);
        check(tag, d, e);
    endtask

    task automatic reg_write(input logic [6:0] a, input logic [63:0] d);
        logic [63:0] clr;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        cyc();
        wr_en = 1'b0;
        if (a[6]) begin
            if (LIVE[a[5:0]]) begin
                mlvl[a[5:0]] = d[5:3];
                mpri[a[5:0]] = d[2:0];
            end
        end else if (a == 0) begin
            clr = d & marm & mflag;
            mflag &= ~clr;
            marm &= ~clr;
        end else if (a == 1) begin
            mmask = d & LIVE;
        end
    endtask

    task automatic pulse(input logic [18:0] e);
        src_evt = e;
        cyc();
        src_evt = '0;
        mflag |= (64'(e) << 8);
    endtask

    task automatic do_ack(input logic [2:0] lv, input string tag, output logic [7:0] v);
        int w;
        logic [63:0] st, es;
        w = model_pick(lv);
        es = (w == 0) ? 64'd0 : 64'({mlvl[w], mpri[w]});
        ack_req = 1'b1; ack_lvl = lv;
        cyc();
        ack_req = 1'b0;
        check({tag, " ack_vld"}, 64'(ack_vld), 64'd1);
        check({tag, " ack_vec"}, 64'(ack_vec), (w == 0) ? 64'h18 : 64'(128 + w));
        v = ack_vec;
        reg_read(7'd2, st);
        check({tag, " status"}, st, es);
    endtask

    task automatic irq_chk(input string tag);
        cyc();
        check(tag, 64'(irq_lvl), 64'(model_irq()));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [7:0]  v;
        logic [63:0] d;
        int unsigned seed;
        for (int s = 0; s < 64; s++) begin mlvl[s] = '0; mpri[s] = '0; end
        seed = 32'd2024;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 irq_lvl", 64'(irq_lvl), 64'd0);
        check("R1 ack_vld", 64'(ack_vld), 64'd0);
        read_chk(7'd0, "R1 flags");
        reg_read(7'd1, d); check("R1 mask", d, 64'h0000_0000_07FF_FF00);
        read_chk(7'd2, "R1 status");
        read_chk(7'd72, "R1 cfg8");
        read_chk(7'd5, "R11 unmapped");

        // R2 dead sources cannot be written
        reg_write(7'd67, 64'h3F);
        reg_read(7'd67, d); check("R2 cfg3", d, 64'd0);
        reg_write(7'd1, '1);
        reg_read(7'd1, d); check("R2 mask live only", d, LIVE);
        reg_write(7'd0, '1);
        read_chk(7'd0, "R2 flags");

        // R3 / R4 clear rules on source 8
        pulse(19'h1);
        reg_write(7'd0, 64'h100);                 // not armed: no clear
        reg_read(7'd0, d); check("R4 unarmed clear ignored", d[8], 1'b1);
        reg_write(7'd0, 64'h0);                   // zero write
        reg_read(7'd0, d); check("R3 write0 no effect", d[8], 1'b1);
        reg_write(7'd0, 64'h100);
        reg_read(7'd0, d); check("R4 armed clear", d[8], 1'b0);

        // R4 clear and event in the same cycle on source 9
        pulse(19'h2);
        reg_read(7'd0, d);
        wr_en = 1'b1; wr_addr = 7'd0; wr_data = 64'h200; src_evt = 19'h2;
        cyc();
        wr_en = 1'b0; src_evt = '0;
        marm[9] = 1'b0;
        reg_read(7'd0, d); check("R4 event beats clear", d[9], 1'b1);
        reg_write(7'd0, 64'h200);
        reg_read(7'd0, d); check("R4 clear after rearm", d[9], 1'b0);

        // R5..R8 directed selection
        reg_write(7'd1, 64'd0);
        reg_write(7'd74, 64'b100101);             // src10 L4 P5
        reg_write(7'd76, 64'b100101);             // src12 L4 P5
        reg_write(7'd84, 64'b100110);             // src20 L4 P6
        reg_write(7'd79, 64'b110000);             // src15 L6 P0
        read_chk(7'd84, "R5 cfg readback");
        pulse(19'h14);                            // src10, src12
        do_ack(3'd4, "R6 tie", v);  check("R6 tie lower src", 64'(v), 64'd138);
        pulse(19'h1000);                          // src20
        do_ack(3'd4, "R6 prio", v); check("R6 higher prio", 64'(v), 64'd148);
        pulse(19'h80);                            // src15
        do_ack(3'd0, "R7 sw", v);   check("R7 level first", 64'(v), 64'd143);
        do_ack(3'd4, "R6 filter", v); check("R6 level only", 64'(v), 64'd148);
        do_ack(3'd2, "R8 spur", v); check("R8 spurious vec", 64'(v), 64'h18);
        reg_write(7'd1, 64'h8000);                // mask src15
        do_ack(3'd0, "R5 masked", v); check("R5 mask gates", 64'(v), 64'd148);
        reg_write(7'd79, 64'b000111);             // src15 level 0
        reg_write(7'd1, 64'd0);
        do_ack(3'd0, "R5 level0", v); check("R5 level0 off", 64'(v), 64'd148);

        // R10 timing of irq_lvl
        irq_chk("R10 before");
        reg_write(7'd86, 64'b111001);             // src22 L7 P1
        pulse(19'h4000);
        check("R10 not yet", 64'(irq_lvl), 64'd4);
        cyc();
        check("R10 one clock later", 64'(irq_lvl), 64'd7);

        // random phase
        for (int it = 0; it < 400; it++) begin
            int op;
            op = $urandom % 6;
            case (op)
                0: pulse(19'($urandom & $urandom & $urandom));
                1: reg_write(7'(64 + 8 + ($urandom % 19)), 64'($urandom % 64));
                2: reg_write(7'd1, {$urandom, $urandom} | {$urandom, $urandom});
                3: do_ack(3'($urandom % 8), "R6 R7 random", v);
                4: begin
                    read_chk(7'd0, "R3 random flags");
                    reg_write(7'd0, {$urandom, $urandom});
                end
                default: irq_chk("R10 random");
            endcase
        end
        read_chk(7'd0, "R4 final flags");
        irq_chk("R10 final");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule